// File: doc/BRIEF.md
# LCD Driver Command Byte Decoder

This block sits behind a serial-bus byte receiver in a low-multiplex LCD driver. It gets bytes that have already been assembled, one per `rx_valid` strobe, together with single-cycle start and stop markers for each transfer. The first bytes of a transfer are commands. Bit 7 of each command says whether another command follows. After the first command whose bit 7 is clear, every remaining byte of the transfer is display data.

Commands are decoded into registered control outputs: multiplex ratio, bias, display enable, low-power mode, display RAM pointer, chip subaddress, input and output bank, and blink settings. A display-data byte is written through a one-cycle RAM write port at the current pointer, and the pointer then advances. Data is dropped when the subaddress chosen by command does not match the strapped `hw_subaddr` pins, so several drivers can share one bus.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After synchronous reset: drive_mode=00 (1:4), disp_en=0, bias_sel=0, low_power=0, ram_ptr=0, dev_sel=0, bank_in=0, bank_out=0, blink_freq=00, blink_mode=0, ram_we=0.
- R2: In command phase, bit 7 of a byte set to 1 keeps the next byte in command phase. Bit 7 cleared moves the decoder to data phase for the rest of the transfer. ram_we pulses only in the cycle after a data-phase byte.
- R3: A command with bits 6:5 = 10 sets, one cycle after the byte, low_power=bit4, disp_en=bit3, bias_sel=bit2 and drive_mode=bits1:0 (01 static, 10 1:2, 11 1:3, 00 1:4).
- R4: A command with bit 6 = 0 loads ram_ptr from bits 4:0 when that value is below DEPTH (24). Larger values leave ram_ptr unchanged.
- R5: A command with bits 6:3 = 1100 sets dev_sel = bits 2:0. A data byte is written only when dev_sel equals hw_subaddr. Otherwise it is dropped and ram_ptr holds.
- R6: A command with bits 6:2 = 11110 sets bank_in = bit1 and bank_out = bit0.
- R7: A command with bits 6:3 = 1110 sets blink_mode = bit2 and blink_freq = bits1:0.
- R8: An accepted data byte gives, in the next cycle, ram_we=1, ram_addr = the pointer before the byte, ram_wdata = the byte, and ram_bank = bank_in. ram_ptr advances by one and wraps from DEPTH-1 to 0.
- R9: xfer_start and xfer_stop each return the decoder to command phase. A byte arriving in the same cycle as xfer_start is treated as a command.
- R10: Command patterns with bits 6:3 = 1101 or bits 6:2 = 11111 change no control output.
- R11: Control outputs and ram_we hold still in the cycle after a cycle with no valid byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_subaddr | input | 3 | Strapped subaddress of this chip |
| xfer_start | input | 1 | Transfer start marker |
| xfer_stop | input | 1 | Transfer stop marker |
| rx_valid | input | 1 | Byte valid strobe |
| rx_byte | input | 8 | Received byte |
| drive_mode | output | 2 | Multiplex selection |
| bias_sel | output | 1 | Bias configuration bit |
| disp_en | output | 1 | Display enable |
| low_power | output | 1 | Low-power mode |
| ram_ptr | output | PTR_W (5) | Current display RAM pointer |
| dev_sel | output | 3 | Subaddress chosen by command |
| bank_in | output | 1 | Bank receiving new data |
| bank_out | output | 1 | Bank shown on the display |
| blink_freq | output | 2 | Blink frequency code |
| blink_mode | output | 1 | Blink mode bit |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | PTR_W (5) | Display RAM write address |
| ram_bank | output | 1 | Display RAM write bank |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
The bench builds the block with the default DEPTH of 24. This value is not a power of two, so the explicit compare-and-wrap variant of the pointer is used. A pointer load can then name addresses 24 to 31, which exercises the out-of-range rejection. Short transfers reach the wrap from 23 to 0 in a few bytes. They also cover subaddress mismatch, and restarts or stops that land in the middle of data.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int ARG_W  = 5;
    localparam int DEV_W  = 3;

    typedef enum logic [2:0] {
        K_NONE,
        K_MODE,
        K_PTR,
        K_DEV,
        K_BANK,
        K_BLINK
    } cmd_kind_e;

    typedef enum logic {
        PH_CMD,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [1:0] mux;
        logic       bias;
        logic       enable;
        logic       low_pwr;
    } mode_cfg_t;

    typedef struct packed {
        logic [1:0] freq;
        logic       mode;
    } blink_cfg_t;

    typedef struct packed {
        logic in_sel;
        logic out_sel;
    } bank_cfg_t;

    typedef struct packed {
        cmd_kind_e        kind;
        logic             more;
        logic [ARG_W-1:0] arg;
        mode_cfg_t        mode;
        blink_cfg_t       blink;
        bank_cfg_t        bank;
        logic [DEV_W-1:0] dev;
    } cmd_fields_t;

    localparam mode_cfg_t  MODE_RST  = '{mux: 2'b00, bias: 1'b0, enable: 1'b0, low_pwr: 1'b0};
    localparam blink_cfg_t BLINK_RST = '{freq: 2'b00, mode: 1'b0};
    localparam bank_cfg_t  BANK_RST  = '{in_sel: 1'b0, out_sel: 1'b0};

    function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
        cmd_kind_e k;
        if (!b[6])                 k = K_PTR;
        else if (!b[5])            k = K_MODE;
        else if (b[4:3] == 2'b00)  k = K_DEV;
        else if (b[4:3] == 2'b10)  k = K_BLINK;
        else if (b[4:3] == 2'b11 && !b[2]) k = K_BANK;
        else                       k = K_NONE;
        return k;
    endfunction

    function automatic cmd_fields_t unpack_cmd(input logic [BYTE_W-1:0] b);
        cmd_fields_t f;
        f.kind         = classify(b);
        f.more         = b[7];
        f.arg          = b[ARG_W-1:0];
        f.mode.mux     = b[1:0];
        f.mode.bias    = b[2];
        f.mode.enable  = b[3];
        f.mode.low_pwr = b[4];
        f.blink.freq   = b[1:0];
        f.blink.mode   = b[2];
        f.bank.in_sel  = b[1];
        f.bank.out_sel = b[0];
        f.dev          = b[DEV_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/lcd_cmd_classify.sv
module lcd_cmd_classify
    import lcd_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output cmd_fields_t       fields
);
    always_comb begin
        fields = unpack_cmd(byte_in);
    end
endmodule

// File: rtl/lcd_cmd_ctrl_regs.sv
module lcd_cmd_ctrl_regs
    import lcd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_en,
    input  cmd_fields_t      fields,
    output mode_cfg_t        mode_q,
    output blink_cfg_t       blink_q,
    output bank_cfg_t        bank_q,
    output logic [DEV_W-1:0] dev_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RST;
            blink_q <= BLINK_RST;
            bank_q  <= BANK_RST;
            dev_q   <= '0;
        end else if (cmd_en) begin
            unique case (fields.kind)
                K_MODE:  mode_q  <= fields.mode;
                K_BLINK: blink_q <= fields.blink;
                K_BANK:  bank_q  <= fields.bank;
                K_DEV:   dev_q   <= fields.dev;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lcd_cmd_dataptr.sv
module lcd_cmd_dataptr
    import lcd_cmd_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ARG_W-1:0]  load_val,
    input  logic              data_en,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              bank_sel,
    output logic [PTR_W-1:0]  ptr_q,
    output logic              we_q,
    output logic [PTR_W-1:0]  addr_q,
    output logic              bank_q,
    output logic [BYTE_W-1:0] wdata_q
);
    localparam int LAST = DEPTH - 1;

    logic [PTR_W-1:0] ptr_inc;
    logic             load_ok;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign ptr_inc = ptr_q + 1'b1;
        end else begin : g_cmp
            assign ptr_inc = (ptr_q == PTR_W'(LAST)) ? '0 : ptr_q + 1'b1;
        end
    endgenerate

    assign load_ok = load_en && (int'(load_val) < DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            bank_q  <= 1'b0;
            wdata_q <= '0;
        end else begin
            we_q <= data_en;
            if (data_en) begin
                addr_q  <= ptr_q;
                bank_q  <= bank_sel;
                wdata_q <= data_in;
                ptr_q   <= ptr_inc;
            end else if (load_ok) begin
                ptr_q <= PTR_W'(load_val);
            end
        end
    end
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEV_W-1:0]  hw_subaddr,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [1:0]        drive_mode,
    output logic              bias_sel,
    output logic              disp_en,
    output logic              low_power,
    output logic [PTR_W-1:0]  ram_ptr,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              bank_in,
    output logic              bank_out,
    output logic [1:0]        blink_freq,
    output logic              blink_mode,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic              ram_bank,
    output logic [BYTE_W-1:0] ram_wdata
);
    phase_e      phase_q, phase_d;
    cmd_fields_t fields;
    mode_cfg_t   mode_q;
    blink_cfg_t  blink_q;
    bank_cfg_t   bank_q;
    logic        is_cmd, is_data, data_ok;

    assign is_cmd  = rx_valid && (xfer_start || phase_q == PH_CMD);
    assign is_data = rx_valid && !xfer_start && phase_q == PH_DATA;
    assign data_ok = is_data && (dev_sel == hw_subaddr);

    always_comb begin
        phase_d = phase_q;
        if (xfer_start) phase_d = PH_CMD;
        if (is_cmd)     phase_d = fields.more ? PH_CMD : PH_DATA;
        if (xfer_stop)  phase_d = PH_CMD;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_CMD;
        else     phase_q <= phase_d;
    end

    lcd_cmd_classify u_classify (
        .byte_in (rx_byte),
        .fields  (fields)
    );

    lcd_cmd_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd_en  (is_cmd),
        .fields  (fields),
        .mode_q  (mode_q),
        .blink_q (blink_q),
        .bank_q  (bank_q),
        .dev_q   (dev_sel)
    );

    lcd_cmd_dataptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load_en  (is_cmd && fields.kind == K_PTR),
        .load_val (fields.arg),
        .data_en  (data_ok),
        .data_in  (rx_byte),
        .bank_sel (bank_q.in_sel),
        .ptr_q    (ram_ptr),
        .we_q     (ram_we),
        .addr_q   (ram_addr),
        .bank_q   (ram_bank),
        .wdata_q  (ram_wdata)
    );

    assign drive_mode = mode_q.mux;
    assign bias_sel   = mode_q.bias;
    assign disp_en    = mode_q.enable;
    assign low_power  = mode_q.low_pwr;
    assign bank_in    = bank_q.in_sel;
    assign bank_out   = bank_q.out_sel;
    assign blink_freq = blink_q.freq;
    assign blink_mode = blink_q.mode;
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
module lcd_cmd_decoder_chk
    import lcd_cmd_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [DEV_W-1:0]  hw_subaddr,
    input logic              xfer_start,
    input logic              xfer_stop,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] rx_byte,
    input logic [1:0]        drive_mode,
    input logic              bias_sel,
    input logic              disp_en,
    input logic              low_power,
    input logic [PTR_W-1:0]  ram_ptr,
    input logic [DEV_W-1:0]  dev_sel,
    input logic              bank_in,
    input logic              bank_out,
    input logic [1:0]        blink_freq,
    input logic              blink_mode,
    input logic              ram_we,
    input logic [PTR_W-1:0]  ram_addr,
    input logic              ram_bank,
    input logic [BYTE_W-1:0] ram_wdata
);
    localparam int LAST = DEPTH - 1;

    logic [PTR_W-1:0] next_after_addr;
    assign next_after_addr = (ram_addr == PTR_W'(LAST)) ? '0 : ram_addr + 1'b1;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(ram_ptr) < DEPTH); // R4

    AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_ptr == next_after_addr); // R8

    AST_WR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(hw_subaddr) == dev_sel); // R5

    AST_WE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(rx_valid) && !$past(xfer_start)); // R2

    AST_QUIET_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !ram_we && $stable({drive_mode, bias_sel, disp_en, low_power,
                                          ram_ptr, dev_sel, bank_in, bank_out,
                                          blink_freq, blink_mode})); // R11
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/lcd_cmd_decoder_tb_top.sv
module lcd_cmd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hw_subaddr = 3'd0;
    logic       xfer_start = 1'b0;
    logic       xfer_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [1:0] drive_mode;
    logic       bias_sel, disp_en, low_power;
    logic [4:0] ram_ptr;
    logic [2:0] dev_sel;
    logic       bank_in, bank_out;
    logic [1:0] blink_freq;
    logic       blink_mode;
    logic       ram_we;
    logic [4:0] ram_addr;
    logic       ram_bank;
    logic [7:0] ram_wdata;

    int total = 0;
    int bad = 0;
    logic       cap_we, cap_bank;
    logic [4:0] cap_addr;
    logic [7:0] cap_data;

    always #4 clk = ~clk;

    lcd_cmd_decoder #(.DEPTH(24)) dut_i (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        cap_we   = ram_we;
        cap_addr = ram_addr;
        cap_data = ram_wdata;
        cap_bank = ram_bank;
    endtask

    task automatic pulse_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); xfer_stop = 1'b1;
        @(negedge clk); xfer_stop = 1'b0;
    endtask

    task automatic t_reset();
        check(drive_mode == 2'b00 && !disp_en && !bias_sel && !low_power, "R1 mode", {drive_mode, disp_en}, 0);
        check(ram_ptr == 0 && dev_sel == 0, "R1 ptr/dev", {ram_ptr, dev_sel}, 0);
        check(!bank_in && !bank_out && blink_freq == 0 && !blink_mode && !ram_we, "R1 bank/blink", {bank_in, bank_out, blink_freq, blink_mode, ram_we}, 0);
    endtask

    task automatic t_mode();
        pulse_start();
        put_byte(8'h5D);
        check(drive_mode == 2'b01, "R3 drive_mode", drive_mode, 1);
        check(low_power && disp_en && bias_sel, "R3 flags", {low_power, disp_en, bias_sel}, 7);
        check(!cap_we, "R2 command no write", cap_we, 0);
    endtask

    task automatic t_chain();
        pulse_start();
        put_byte(8'h85);
        check(ram_ptr == 5, "R4 pointer load", ram_ptr, 5);
        put_byte(8'hE0);
        check(dev_sel == 0 && !cap_we, "R5 dev select / R2 continuation", {dev_sel, cap_we}, 0);
        put_byte(8'hFA);
        check(bank_in && !bank_out, "R6 bank", {bank_in, bank_out}, 2);
        put_byte(8'h76);
        check(blink_mode && blink_freq == 2'b10, "R7 blink", {blink_freq, blink_mode}, 5);
        check(!cap_we, "R2 last command no write", cap_we, 0);
        put_byte(8'hAA);
        check(cap_we && cap_addr == 5 && cap_data == 8'hAA && cap_bank, "R8 first data", {cap_we, cap_addr, cap_data}, {1'b1, 5'd5, 8'hAA});
        check(ram_ptr == 6, "R8 ptr advance", ram_ptr, 6);
        put_byte(8'hBB);
        check(cap_we && cap_addr == 6 && cap_data == 8'hBB, "R2 data phase persists", {cap_we, cap_addr, cap_data}, {1'b1, 5'd6, 8'hBB});
        check(ram_ptr == 7, "R8 ptr advance 2", ram_ptr, 7);
    endtask

    task automatic t_wrap();
        pulse_start();
        put_byte(8'h17);
        check(ram_ptr == 23, "R4 pointer 23", ram_ptr, 23);
        put_byte(8'h11);
        check(cap_we && cap_addr == 23, "R8 write at 23", cap_addr, 23);
        check(ram_ptr == 0, "R8 wrap to 0", ram_ptr, 0);
        put_byte(8'h22);
        check(cap_we && cap_addr == 0 && ram_ptr == 1, "R8 after wrap", {cap_addr, ram_ptr}, 1);
    endtask

    task automatic t_mismatch();
        pulse_start();
        put_byte(8'h63);
        check(dev_sel == 3, "R5 dev select 3", dev_sel, 3);
        put_byte(8'h33);
        check(!cap_we && ram_ptr == 1, "R5 mismatch dropped", {cap_we, ram_ptr}, 1);
        hw_subaddr = 3'd3;
        put_byte(8'h44);
        check(cap_we && cap_addr == 1 && cap_data == 8'h44, "R5 match written", {cap_we, cap_addr, cap_data}, {1'b1, 5'd1, 8'h44});
    endtask

    task automatic t_restart();
        pulse_start();
        put_byte(8'h42);
        check(!cap_we, "R9 start returns to command", cap_we, 0);
        check(drive_mode == 2'b10 && !disp_en, "R9 byte decoded as mode", {drive_mode, disp_en}, 4);
        put_byte(8'h55);
        check(cap_we && cap_data == 8'h55, "R2 data after last command", cap_data, 8'h55);
        pulse_stop();
        put_byte(8'h4E);
        check(!cap_we && drive_mode == 2'b10 && disp_en && bias_sel, "R9 stop returns to command", {cap_we, disp_en, bias_sel}, 3);
    endtask

    task automatic t_edges();
        logic [4:0] p;
        pulse_start();
        p = ram_ptr;
        put_byte(8'h9A);
        check(ram_ptr == p, "R4 out-of-range pointer ignored", ram_ptr, p);
        put_byte(8'hFF);
        check(ram_ptr == p && drive_mode == 2'b10 && dev_sel == 3 && bank_in && !bank_out && blink_freq == 2'b10 && blink_mode,
              "R10 reserved 11111 no effect", {drive_mode, dev_sel, blink_freq}, {2'b10, 3'd3, 2'b10});
        pulse_start();
        put_byte(8'hE8);
        check(ram_ptr == p && disp_en && dev_sel == 3 && bank_in && blink_mode && blink_freq == 2'b10,
              "R10 reserved 1101 no effect", {dev_sel, blink_freq}, {3'd3, 2'b10});
        @(negedge clk);
        check(!ram_we && ram_ptr == p, "R11 idle quiet", {ram_we, ram_ptr}, p);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode();
        t_chain();
        t_wrap();
        t_mismatch();
        t_restart();
        t_edges();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule